// File: doc/BRIEF.md
# Shared Interrupt Routing and Best-Pending Selector

This block takes the state of every shared interrupt and works out, for each processor interface, which pending interrupt that processor should see next. The state comes in as flat vectors: pending, enable, active, priority, group, the two group enables, and a 64-bit routing word for each interrupt. A table of 32-bit processor affinity values and one participation flag per processor complete the picture. Each interrupt goes to a single processor, either through an exact affinity match or to the lowest-numbered processor that is currently participating.

A scan counter visits one interrupt index per clock. Each processor has its own running best record. At the end of a sweep the record becomes that processor's published result: valid flag, interrupt ID, priority and group. A processor may pulse its clear-winner input to drop its result. It then stays without a result until a sweep that starts after the clear has finished.

No data stream crosses the block's edge, so there is no valid/ready handshake. All outputs are level signals that hold their value between sweep ends, and inputs are sampled whenever the counter reaches their index. Acknowledge and end-of-interrupt handling belong to other blocks.

Top module: `irq_affinity_selector`

## Requirements
- R1: After reset, every processor result reads valid 0, ID 1023, priority 0xFF and group 0. It stays so until the first sweep completes.
- R2: An interrupt is a candidate only when all of the following hold: it is pending, it is enabled, it is not active, and its group is enabled. Group 0 is gated by grp_enable[0] and group 1 by grp_enable[1].
- R3: When bit 31 of the routing word is 0, the target affinity is built from four routing-word fields:
  - bits 39:32 give the top byte
  - bits 23:16 give the next byte
  - bits 15:8 give the byte after that
  - bits 7:0 give the bottom byte

  The interrupt goes to the processor whose affinity equals this value, taking the lowest index if several match. Bits 30:24 and 63:40 have no effect.
- R4: When bit 31 of the routing word is 1, the interrupt goes to the lowest-index processor whose participation flag is 1.
- R5: An interrupt with no target processor is skipped and never appears in any result. This covers both no affinity match and, when bit 31 is set, no participating processor.
- R6: Among the candidates routed to a processor, the one with the numerically lowest priority value wins.
- R7: When priority values are equal, the lowest interrupt ID wins. The ID of the interrupt at index i is ID_BASE + i.
- R8: A valid result carries the winner's ID, priority and group.
- R9: A processor with no candidate shows valid 0, ID 1023, priority 0xFF and group 0.
- R10: The block scans one index per clock, so a sweep takes NUM_IRQ clocks. Results change only at the clock edge that scans the last index, or on a clear.
- R11: A clear-winner pulse sets that processor's result to the empty record (R9) at the next edge. The sweep in progress during the pulse does not publish for that processor. The following full sweep does.
- R12: A clear-winner pulse on one processor leaves every other processor's result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pending | input | NUM_IRQ | Pending bit of each interrupt |
| irq_enable | input | NUM_IRQ | Enable bit of each interrupt |
| irq_active | input | NUM_IRQ | Active bit of each interrupt |
| irq_group | input | NUM_IRQ | Group of each interrupt (0 or 1) |
| irq_prio | input | NUM_IRQ x PRIO_W | Priority value of each interrupt, lower is more urgent |
| irq_route | input | NUM_IRQ x 64 | Routing word of each interrupt |
| grp_enable | input | 2 | Group enables, bit g enables group g |
| pe_affinity | input | NUM_PE x 32 | Affinity value of each processor |
| pe_participate | input | NUM_PE | Processor accepts any-processor interrupts |
| pe_clear | input | NUM_PE | Clear-winner pulse of each processor |
| pe_win_valid | output | NUM_PE | Result valid |
| pe_win_id | output | NUM_PE x 10 | Winning interrupt ID, 1023 when none |
| pe_win_prio | output | NUM_PE x PRIO_W | Winning priority, 0xFF when none |
| pe_win_grp | output | NUM_PE | Winning group, 0 when none |

## Verification
The main function is exercised with several input patterns:
- Single interrupts routed by exact affinity to different processors. These separate correct field assembly of the routing word from a mixed-up byte order, and show that junk in the unused bits is ignored.
- Sets that differ only in one of the pending, enable, active or group-enable conditions. Each of these isolates one term of the candidate rule.
- Equal and unequal priorities placed at low and high indices. These distinguish priority ordering from ID ordering.
- Any-processor routing under changing participation masks, plus an affinity that nobody owns. These cover the first-participant choice and the skip path.
- New inputs and clear pulses timed against the scan phase. These confirm that results move only at sweep ends and that a cleared processor skips the sweep it was cleared in.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int AFF_W  = 32;
  localparam int ROUTE_W = 64;
  localparam logic [ID_W-1:0] NO_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
    logic              grp;
  } win_t;

  function automatic win_t empty_win();
    win_t w;
    w.valid = 1'b0;
    w.id    = NO_ID;
    w.prio  = IDLE_PRIO;
    w.grp   = 1'b0;
    return w;
  endfunction

  // Strict ordering: lower priority value first, then lower ID.
  function automatic logic beats(win_t a, win_t b);
    return (a.prio < b.prio) || ((a.prio == b.prio) && (a.id < b.id));
  endfunction

endpackage

// File: rtl/irq_sel_scan.sv
module irq_sel_scan #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx,
  output logic             first,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IRQ - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idx <= '0;
    else if (idx == LAST_IDX) idx <= '0;
    else                    idx <= idx + 1'b1;
  end

  assign first = (idx == '0);
  assign last  = (idx == LAST_IDX);

  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> first);

  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/irq_sel_route.sv
module irq_sel_route
  import irq_sel_pkg::*;
#(
  parameter int NUM_PE = 4
) (
  input  logic [ROUTE_W-1:0]           route,
  input  logic [NUM_PE-1:0][AFF_W-1:0] pe_affinity,
  input  logic [NUM_PE-1:0]            pe_participate,
  output logic [NUM_PE-1:0]            target
);

  localparam int ANY_BIT = 31;

  logic             any_mode;
  logic [AFF_W-1:0] want_aff;
  logic [NUM_PE-1:0] eligible;

  assign any_mode = route[ANY_BIT];
  assign want_aff = {route[39:32], route[23:16], route[15:8], route[7:0]};

  genvar g;
  generate
    for (g = 0; g < NUM_PE; g++) begin : g_elig
      assign eligible[g] = any_mode ? pe_participate[g]
                                    : (pe_affinity[g] == want_aff);
    end
  endgenerate

  // Lowest eligible index wins: isolate the lowest set bit.
  always_comb begin
    target = eligible & (~eligible + 1'b1);
  end

endmodule

// File: rtl/irq_sel_track.sv
module irq_sel_track
  import irq_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic last,
  input  logic hit,
  input  win_t cand,
  input  logic clr,
  output win_t result
);

  win_t acc_q, acc_d;
  logic fresh_q;
  logic take;

  assign take = hit && (!acc_q.valid || beats(cand, acc_q));

  always_comb begin
    if (first)      acc_d = hit ? cand : empty_win();
    else if (take)  acc_d = cand;
    else            acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= empty_win();
    else        acc_q <= acc_d;
  end

  // fresh_q: the current sweep began with no clear since its start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fresh_q <= 1'b0;
    else if (clr)    fresh_q <= 1'b0;
    else if (first)  fresh_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 result <= empty_win();
    else if (clr)               result <= empty_win();
    else if (last && fresh_q)   result <= acc_d;
  end

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!result.valid && result.id == NO_ID));

  assert_hold_mid_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!last && !clr) |=> $stable(result));

  assert_empty_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !result.valid |-> (result.id == NO_ID && result.prio == IDLE_PRIO));

  assert_no_worse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!first && acc_q.valid) |=> (acc_q.valid && acc_q.prio <= $past(acc_q.prio)));

endmodule

// File: rtl/irq_affinity_selector.sv
module irq_affinity_selector
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_PE  = 4,
  parameter int ID_BASE = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_IRQ-1:0]                 irq_pending,
  input  logic [NUM_IRQ-1:0]                 irq_enable,
  input  logic [NUM_IRQ-1:0]                 irq_active,
  input  logic [NUM_IRQ-1:0]                 irq_group,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0]     irq_prio,
  input  logic [NUM_IRQ-1:0][ROUTE_W-1:0]    irq_route,
  input  logic [1:0]                         grp_enable,
  input  logic [NUM_PE-1:0][AFF_W-1:0]       pe_affinity,
  input  logic [NUM_PE-1:0]                  pe_participate,
  input  logic [NUM_PE-1:0]                  pe_clear,
  output logic [NUM_PE-1:0]                  pe_win_valid,
  output logic [NUM_PE-1:0][ID_W-1:0]        pe_win_id,
  output logic [NUM_PE-1:0][PRIO_W-1:0]      pe_win_prio,
  output logic [NUM_PE-1:0]                  pe_win_grp
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [IDX_W-1:0]  idx;
  logic              first, last;
  logic              cand_ok;
  win_t              cand;
  logic [NUM_PE-1:0] target;
  logic [NUM_PE-1:0] hit;

  irq_sel_scan #(.NUM_IRQ(NUM_IRQ)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (idx),
    .first (first),
    .last  (last)
  );

  assign cand_ok = irq_pending[idx] && irq_enable[idx] && !irq_active[idx]
                && grp_enable[irq_group[idx]];

  always_comb begin
    cand.valid = 1'b1;
    cand.id    = ID_W'(ID_BASE) + ID_W'(idx);
    cand.prio  = irq_prio[idx];
    cand.grp   = irq_group[idx];
  end

  irq_sel_route #(.NUM_PE(NUM_PE)) u_route (
    .route          (irq_route[idx]),
    .pe_affinity    (pe_affinity),
    .pe_participate (pe_participate),
    .target         (target)
  );

  assign hit = cand_ok ? target : '0;

  genvar p;
  generate
    for (p = 0; p < NUM_PE; p++) begin : g_pe
      win_t res;
      irq_sel_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .first  (first),
        .last   (last),
        .hit    (hit[p]),
        .cand   (cand),
        .clr    (pe_clear[p]),
        .result (res)
      );
      assign pe_win_valid[p] = res.valid;
      assign pe_win_id[p]    = res.id;
      assign pe_win_prio[p]  = res.prio;
      assign pe_win_grp[p]   = res.grp;
    end
  endgenerate

  assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  assert_ungated_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_ok |-> (hit == '0));

  assert_any_mode_part_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_ok && irq_route[idx][31]) |-> ((hit & ~pe_participate) == '0));

endmodule

// File: tb/test_irq_affinity_selector.sv
`timescale 1ns/1ps
module test_irq_affinity_selector;

  localparam int N = 32;
  localparam int P = 4;
  localparam int BASE = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_pending, irq_enable, irq_active, irq_group;
  logic [N-1:0][7:0]  irq_prio;
  logic [N-1:0][63:0] irq_route;
  logic [1:0] grp_enable;
  logic [P-1:0][31:0] pe_affinity;
  logic [P-1:0] pe_participate, pe_clear;
  logic [P-1:0] pe_win_valid, pe_win_grp;
  logic [P-1:0][9:0] pe_win_id;
  logic [P-1:0][7:0] pe_win_prio;

  int checks = 0, fails = 0;
  int ecnt = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  irq_affinity_selector #(.NUM_IRQ(N), .NUM_PE(P), .ID_BASE(BASE)) i_irq_affinity_selector (
    .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .irq_enable(irq_enable),
    .irq_active(irq_active), .irq_group(irq_group), .irq_prio(irq_prio),
    .irq_route(irq_route), .grp_enable(grp_enable), .pe_affinity(pe_affinity),
    .pe_participate(pe_participate), .pe_clear(pe_clear), .pe_win_valid(pe_win_valid),
    .pe_win_id(pe_win_id), .pe_win_prio(pe_win_prio), .pe_win_grp(pe_win_grp));

  function automatic logic [63:0] mk_route(logic any, logic [31:0] a);
    logic [63:0] r;
    r = {24'hA5A5A5, a[31:24], any, 7'h55, a[23:16], a[15:8], a[7:0]};
    return r;
  endfunction

  task automatic chk(int pe, logic v, int id, int pr, logic g, string req);
    checks++;
    if (pe_win_valid[pe] !== v || pe_win_id[pe] !== 10'(id) ||
        pe_win_prio[pe] !== 8'(pr) || pe_win_grp[pe] !== g) begin
      fails++;
      $display("FAIL %s pe%0d: got v=%0b id=%0d prio=%0h grp=%0b, exp v=%0b id=%0d prio=%0h grp=%0b",
               req, pe, pe_win_valid[pe], pe_win_id[pe], pe_win_prio[pe], pe_win_grp[pe],
               v, id, pr, g);
    end
  endtask

  task automatic chk_none(int pe, string req);
    chk(pe, 1'b0, 1023, 8'hFF, 1'b0, req);
  endtask

  // Wait for the negedge following the edge that scanned index k.
  task automatic after_idx(int k);
    do @(negedge clk); while (ecnt == 0 || ((ecnt - 1) % N) != k);
  endtask

  task automatic settle();
    after_idx(N-1);
    after_idx(N-1);
  endtask

  task automatic clear_inputs();
    irq_pending = '0; irq_enable = '0; irq_active = '0; irq_group = '0;
    irq_prio = '0; irq_route = '0; grp_enable = 2'b11; pe_clear = '0;
    pe_participate = 4'hF;
    pe_affinity[0] = 32'h0000_0100;
    pe_affinity[1] = 32'h0000_0001;
    pe_affinity[2] = 32'h0001_0000;
    pe_affinity[3] = 32'h0100_0002;
  endtask

  task automatic set_irq(int i, int pr, logic g, logic any, logic [31:0] a);
    irq_pending[i] = 1'b1; irq_enable[i] = 1'b1; irq_active[i] = 1'b0;
    irq_prio[i] = 8'(pr); irq_group[i] = g; irq_route[i] = mk_route(any, a);
  endtask

  task automatic t_reset();
    for (int p = 0; p < P; p++) chk_none(p, "R1");
  endtask

  task automatic t_affinity();
    clear_inputs();
    set_irq(3, 8'h40, 0, 0, 32'h0001_0000);
    set_irq(10, 8'h20, 0, 0, 32'h0001_0000);
    set_irq(5, 8'h80, 1, 0, 32'h0100_0002);
    settle();
    chk(2, 1, BASE+10, 8'h20, 0, "R3/R6");
    chk(3, 1, BASE+5, 8'h80, 1, "R3/R8");
    chk_none(0, "R9");
    chk_none(1, "R9");
    // duplicate affinity: lowest index receives
    pe_affinity[3] = 32'h0000_0001;
    irq_route[5] = mk_route(0, 32'h0000_0001);
    settle();
    chk(1, 1, BASE+5, 8'h80, 1, "R3 lowest match");
    chk_none(3, "R3 lowest match");
  endtask

  task automatic t_candidacy();
    clear_inputs();
    set_irq(3, 8'h10, 0, 0, 32'h0000_0001); irq_active[3] = 1'b1;
    set_irq(4, 8'h11, 0, 0, 32'h0000_0001); irq_enable[4] = 1'b0;
    set_irq(8, 8'h12, 0, 0, 32'h0000_0001); irq_pending[8] = 1'b0;
    set_irq(6, 8'h05, 1, 0, 32'h0000_0001); grp_enable = 2'b01;
    set_irq(7, 8'h90, 0, 0, 32'h0000_0001);
    settle();
    chk(1, 1, BASE+7, 8'h90, 0, "R2");
    grp_enable = 2'b11;
    settle();
    chk(1, 1, BASE+6, 8'h05, 1, "R2 group on");
    grp_enable = 2'b10;
    settle();
    chk(1, 1, BASE+6, 8'h05, 1, "R2 group0 off");
  endtask

  task automatic t_order();
    clear_inputs();
    set_irq(20, 8'h30, 0, 0, 32'h0000_0100);
    set_irq(9, 8'h30, 1, 0, 32'h0000_0100);
    settle();
    chk(0, 1, BASE+9, 8'h30, 1, "R7");
    set_irq(25, 8'h2F, 0, 0, 32'h0000_0100);
    settle();
    chk(0, 1, BASE+25, 8'h2F, 0, "R6");
  endtask

  task automatic t_any();
    clear_inputs();
    set_irq(12, 8'h44, 0, 1, 32'h0000_0100);
    pe_participate = 4'b1100;
    settle();
    chk(2, 1, BASE+12, 8'h44, 0, "R4");
    chk_none(0, "R4");
    pe_participate = 4'b0000;
    set_irq(13, 8'h01, 0, 0, 32'hDEAD_BEEF);
    settle();
    for (int p = 0; p < P; p++) chk_none(p, "R5");
  endtask

  task automatic t_clear();
    clear_inputs();
    set_irq(3, 8'h40, 0, 0, 32'h0001_0000);
    set_irq(5, 8'h50, 1, 0, 32'h0100_0002);
    settle();
    chk(2, 1, BASE+3, 8'h40, 0, "R11 pre");
    after_idx(9);
    pe_clear[2] = 1'b1;
    @(negedge clk);
    pe_clear[2] = 1'b0;
    chk_none(2, "R11 drop");
    chk(3, 1, BASE+5, 8'h50, 1, "R12");
    after_idx(N-1);
    chk_none(2, "R11 skip sweep");
    after_idx(N-1);
    chk(2, 1, BASE+3, 8'h40, 0, "R11 republish");
  endtask

  task automatic t_timing();
    clear_inputs();
    set_irq(20, 8'h30, 0, 0, 32'h0000_0100);
    settle();
    set_irq(2, 8'h10, 0, 0, 32'h0000_0100);
    after_idx(N-2);
    chk(0, 1, BASE+20, 8'h30, 0, "R10 hold");
    after_idx(N-1);
    chk(0, 1, BASE+2, 8'h10, 0, "R10 publish");
  endtask

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    after_idx(N-2);
    t_reset();
    t_affinity();
    t_candidacy();
    t_order();
    t_any();
    t_clear();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule